// File: doc/BRIEF.md
# Prioritized Dual-Output Interrupt Controller

The block gathers a bank of level-sensitive interrupt inputs and drives two request lines to a processor: a normal request (`irq_o`) and a fast request (`fiq_o`). A 32-bit register port configures it. Sources are switched on or off one at a time: software writes the source number to a set register or a clear register. A per-source route bit sends each source to one of the two lines. Every normal source carries a 4-bit priority, and a global threshold hides the normal sources whose priority does not exceed it. Test bits can raise any source without touching its input.

A status register names the winning normal source. This is the pending, unhidden normal source with the highest priority. When two such sources share a level, the higher source number wins. Both request lines and the status are registered, so they follow the inputs by one clock.

Top module: `icu_top`

## Requirements
- R1: A write to the set-number register (word 1) sets the enable bit of the source named by the low 6 data bits and changes no other enable bit. The enable bits read back at words 24 (sources 0–31) and 25 (sources 32–63), with bit k of a word standing for source 32·w+k.
- R2: A write to the clear-number register (word 2) clears the enable bit of the source named by the low 6 data bits, and changes no other bit. A disabled source drives neither output.
- R3: Route words 8 (sources 0–31) and 9 (sources 32–63) hold one bit per source. A 1 sends the source to `fiq_o` and a 0 sends it to `irq_o`.
- R4: The priority of source n is the 4-bit field at bits 4·(n mod 8)+3 : 4·(n mod 8) of priority word 32 + n/8.
- R5: A source is pending when it is enabled and either its input or its test bit is 1. An input on a disabled source has no effect on either output.
- R6: Test words 16 (sources 0–31) and 17 (sources 32–63) raise a source exactly as a high input would.
- R7: The threshold at word 0 is 5 bits wide. With a value below 16, a normal source whose priority is at or below the value is hidden. With bit 4 set, nothing is hidden. `irq_o` is the OR of the pending, unhidden normal sources.
- R8: `fiq_o` is the OR of the pending fast-routed sources, and the threshold has no effect on it.
- R9: The status word (word 3) holds the number of the winning normal source. Ties go to the higher number. The word is all ones when no normal source is pending and unhidden.
- R10: After reset, all enable, route, priority and test bits are 0, the threshold reads 0x1F, and both outputs are low.
- R11: Read data appears on `bus_rdata_o` one clock after the read strobe. The outputs respond one clock after a change on `src_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Level interrupt inputs |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one clock after the strobe |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the block with NSRC = 64. This gives two words for each bit-per-source register and eight priority words. Sources at both ends of the range (0–31 and 32–63) and the top word of the priority file are all exercised, along with the 6-bit number masking. A set or clear value of 64 or more wraps back onto a low source. Tied priorities, a threshold exactly equal to a source's priority, and a threshold of 16 are all reached with a few enabled sources.

// File: rtl/icu_pkg.sv
package icu_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 6;
    localparam int PRIO_W  = 4;
    localparam int LVL_W   = 5;
    // word addresses; groups are sized by the source count
    localparam int A_LEVEL  = 0;
    localparam int A_ENSET  = 1;
    localparam int A_ENCLR  = 2;
    localparam int A_STATUS = 3;
    localparam int A_ROUTE  = 8;
    localparam int A_TEST   = 16;
    localparam int A_ENRD   = 24;
    localparam int A_PRIO   = 32;
    localparam logic [LVL_W-1:0] LEVEL_RST = 5'h1F;
endpackage

// File: rtl/icu_regs.sv
module icu_regs #(
    parameter int NSRC = 64
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_i,
    input  logic                                   rd_i,
    input  logic [icu_pkg::ADDR_W-1:0]             addr_i,
    input  logic [icu_pkg::DATA_W-1:0]             wdata_i,
    input  logic [icu_pkg::DATA_W-1:0]             status_i,
    output logic [icu_pkg::DATA_W-1:0]             rdata_o,
    output logic [NSRC-1:0]                        en_o,
    output logic [NSRC-1:0]                        route_o,
    output logic [NSRC-1:0]                        test_o,
    output logic [NSRC*icu_pkg::PRIO_W-1:0]        prio_o,
    output logic [icu_pkg::LVL_W-1:0]              level_o
);
    import icu_pkg::*;

    localparam int NWORD = NSRC / DATA_W;
    localparam int NPW   = NSRC * PRIO_W / DATA_W;
    localparam int ID_W  = $clog2(NSRC);

    typedef struct packed {
        logic [NSRC-1:0]        en;
        logic [NSRC-1:0]        route;
        logic [NSRC-1:0]        test;
        logic [NSRC*PRIO_W-1:0] prio;
        logic [LVL_W-1:0]       level;
        logic [DATA_W-1:0]      rdata;
    } regs_t;

    regs_t reg_d, reg_q;

    always_comb begin
        int a;
        int num;
        reg_d       = reg_q;
        reg_d.rdata = '0;
        a           = int'(addr_i);
        num         = int'(wdata_i[ID_W-1:0]);
        if (wr_i) begin
            if (a == A_LEVEL) begin
                reg_d.level = wdata_i[LVL_W-1:0];
            end else if (a == A_ENSET) begin
                if (num < NSRC) reg_d.en[num] = 1'b1;
            end else if (a == A_ENCLR) begin
                if (num < NSRC) reg_d.en[num] = 1'b0;
            end else if (a >= A_ROUTE && a < A_ROUTE + NWORD) begin
                reg_d.route[(a - A_ROUTE)*DATA_W +: DATA_W] = wdata_i;
            end else if (a >= A_TEST && a < A_TEST + NWORD) begin
                reg_d.test[(a - A_TEST)*DATA_W +: DATA_W] = wdata_i;
            end else if (a >= A_PRIO && a < A_PRIO + NPW) begin
                reg_d.prio[(a - A_PRIO)*DATA_W +: DATA_W] = wdata_i;
            end
        end
        if (rd_i) begin
            if (a == A_LEVEL) begin
                reg_d.rdata = {{(DATA_W-LVL_W){1'b0}}, reg_q.level};
            end else if (a == A_STATUS) begin
                reg_d.rdata = status_i;
            end else if (a >= A_ROUTE && a < A_ROUTE + NWORD) begin
                reg_d.rdata = reg_q.route[(a - A_ROUTE)*DATA_W +: DATA_W];
            end else if (a >= A_TEST && a < A_TEST + NWORD) begin
                reg_d.rdata = reg_q.test[(a - A_TEST)*DATA_W +: DATA_W];
            end else if (a >= A_ENRD && a < A_ENRD + NWORD) begin
                reg_d.rdata = reg_q.en[(a - A_ENRD)*DATA_W +: DATA_W];
            end else if (a >= A_PRIO && a < A_PRIO + NPW) begin
                reg_d.rdata = reg_q.prio[(a - A_PRIO)*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q       <= '0;
            reg_q.level <= LEVEL_RST;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign en_o    = reg_q.en;
    assign route_o = reg_q.route;
    assign test_o  = reg_q.test;
    assign prio_o  = reg_q.prio;
    assign level_o = reg_q.level;
    assign rdata_o = reg_q.rdata;
endmodule

// File: rtl/icu_arbiter.sv
module icu_arbiter #(
    parameter int NSRC = 64,
    localparam int ID_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]                 req_i,
    input  logic [NSRC*icu_pkg::PRIO_W-1:0] prio_i,
    input  logic [icu_pkg::LVL_W-1:0]       level_i,
    output logic [NSRC-1:0]                 pass_o,
    output logic                            valid_o,
    output logic [ID_W-1:0]                 id_o
);
    import icu_pkg::*;

    // per-source threshold compare
    for (genvar n = 0; n < NSRC; n++) begin : g_pass
        assign pass_o[n] = req_i[n] &&
            (level_i[LVL_W-1] || (prio_i[n*PRIO_W +: PRIO_W] > level_i[PRIO_W-1:0]));
    end

    // ascending scan with >= lets a later (higher) number win a tie
    always_comb begin
        logic [PRIO_W-1:0] best_p;
        valid_o = 1'b0;
        id_o    = '0;
        best_p  = '0;
        for (int n = 0; n < NSRC; n++) begin
            if (pass_o[n] && (!valid_o || prio_i[n*PRIO_W +: PRIO_W] >= best_p)) begin
                valid_o = 1'b1;
                best_p  = prio_i[n*PRIO_W +: PRIO_W];
                id_o    = ID_W'(n);
            end
        end
    end
endmodule

// File: rtl/icu_top.sv
module icu_top #(
    parameter int NSRC = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSRC-1:0]              src_i,
    input  logic                         bus_wr_i,
    input  logic                         bus_rd_i,
    input  logic [icu_pkg::ADDR_W-1:0]   bus_addr_i,
    input  logic [icu_pkg::DATA_W-1:0]   bus_wdata_i,
    output logic [icu_pkg::DATA_W-1:0]   bus_rdata_o,
    output logic                         irq_o,
    output logic                         fiq_o
);
    import icu_pkg::*;

    localparam int ID_W = $clog2(NSRC);

    typedef struct packed {
        logic              irq;
        logic              fiq;
        logic [DATA_W-1:0] status;
    } out_t;

    out_t out_d, out_q;

    logic [NSRC-1:0]        en_w, route_w, test_w, pend_w, irq_cand_w, fiq_cand_w, pass_w;
    logic [NSRC*PRIO_W-1:0] prio_w;
    logic [LVL_W-1:0]       level_w;
    logic                   arb_valid;
    logic [ID_W-1:0]        arb_id;

    icu_regs #(.NSRC(NSRC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr_i),
        .rd_i     (bus_rd_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .status_i (out_q.status),
        .rdata_o  (bus_rdata_o),
        .en_o     (en_w),
        .route_o  (route_w),
        .test_o   (test_w),
        .prio_o   (prio_w),
        .level_o  (level_w)
    );

    assign pend_w     = en_w & (src_i | test_w);
    assign irq_cand_w = pend_w & ~route_w;
    assign fiq_cand_w = pend_w & route_w;

    icu_arbiter #(.NSRC(NSRC)) u_arb (
        .req_i   (irq_cand_w),
        .prio_i  (prio_w),
        .level_i (level_w),
        .pass_o  (pass_w),
        .valid_o (arb_valid),
        .id_o    (arb_id)
    );

    always_comb begin
        out_d.irq    = |pass_w;
        out_d.fiq    = |fiq_cand_w;
        out_d.status = arb_valid ? DATA_W'(arb_id) : '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q        <= '0;
            out_q.status <= '1;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_o = out_q.irq;
    assign fiq_o = out_q.fiq;
endmodule

// File: rtl/icu_chk.sv
module icu_chk #(
    parameter int NSRC = 64,
    localparam int ID_W = $clog2(NSRC)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_i,
    input logic [icu_pkg::ADDR_W-1:0]   addr_i,
    input logic [ID_W-1:0]              num_i,
    input logic [NSRC-1:0]              en_i,
    input logic [NSRC-1:0]              irq_cand_i,
    input logic [NSRC-1:0]              fiq_cand_i,
    input logic [icu_pkg::LVL_W-1:0]    level_i,
    input logic [icu_pkg::DATA_W-1:0]   status_i,
    input logic                         irq_o,
    input logic                         fiq_o
);
    import icu_pkg::*;

    assert_enset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && int'(addr_i) == A_ENSET) |=> en_i[$past(num_i)]);

    assert_enclr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && int'(addr_i) == A_ENCLR) |=> !en_i[$past(num_i)]);

    assert_no_enable_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0) |=> (!irq_o && !fiq_o));

    assert_open_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i[LVL_W-1] && (irq_cand_i != '0)) |=> irq_o);

    assert_fast_unmasked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_cand_i != '0) |=> fiq_o);

    assert_status_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (status_i == '1));

    assert_status_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_i < DATA_W'(NSRC)));
endmodule

bind icu_top icu_chk #(.NSRC(NSRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (bus_wr_i),
    .addr_i     (bus_addr_i),
    .num_i      (bus_wdata_i[ID_W-1:0]),
    .en_i       (en_w),
    .irq_cand_i (irq_cand_w),
    .fiq_cand_i (fiq_cand_w),
    .level_i    (level_w),
    .status_i   (out_q.status),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o)
);

// File: tb/icu_top_tb.sv
module icu_top_tb;
    localparam int NSRC = 64;
    localparam logic [31:0] NONE = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;
    int          nvec = 0, nbad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    icu_top #(.NSRC(NSRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    typedef struct packed {
        logic [63:0] s;
        logic [4:0]  lvl;
        logic        eirq;
        logic        efiq;
        logic [31:0] est;
    } vec_t;

    // enabled: 3(p5) 10(p9) 20(p9) 63(p2) normal, 40 fast
    localparam vec_t VEC [12] = '{
        '{64'h0,                  5'd31, 1'b0, 1'b0, NONE },
        '{64'h8,                  5'd31, 1'b1, 1'b0, 32'd3 },
        '{64'h408,                5'd31, 1'b1, 1'b0, 32'd10},
        '{64'h10_0408,            5'd31, 1'b1, 1'b0, 32'd20},
        '{64'h100_0000_0000,      5'd31, 1'b0, 1'b1, NONE },
        '{64'h8000_0000_0000_0008,5'd4,  1'b1, 1'b0, 32'd3 },
        '{64'h8000_0000_0000_0008,5'd5,  1'b0, 1'b0, NONE },
        '{64'h100_0000_0000,      5'd0,  1'b0, 1'b1, NONE },
        '{64'h20,                 5'd31, 1'b0, 1'b0, NONE },
        '{64'h8000_0000_0000_0000,5'd1,  1'b1, 1'b0, 32'd63},
        '{64'h8000_0000_0000_0000,5'd2,  1'b0, 1'b0, NONE },
        '{64'h100_0010_0400,      5'd16, 1'b1, 1'b1, 32'd20}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input int a, input logic [31:0] d);
        addr = 6'(a); wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0;
    endtask

    task automatic rd_reg(input int a, output logic [31:0] d);
        addr = 6'(a); rd = 1'b1;
        tick();
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic settle();
        tick();
        tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        nvec++; nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        @(negedge clk);
        @(negedge clk);
        // R10 reset state
        check("R10 irq", {31'b0, irq}, 32'd0);
        check("R10 fiq", {31'b0, fiq}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_reg(0, r);  check("R10 level", r, 32'h1F);
        rd_reg(24, r); check("R10 enable lo", r, 32'h0);
        rd_reg(9, r);  check("R10 route hi", r, 32'h0);
        rd_reg(39, r); check("R10 prio word7", r, 32'h0);
        rd_reg(3, r);  check("R10 status", r, NONE);

        // R1 one-at-a-time enable
        wr_reg(1, 32'd3);
        rd_reg(24, r); check("R1 enable 3", r, 32'h8);
        wr_reg(1, 32'd10); wr_reg(1, 32'd20); wr_reg(1, 32'd40); wr_reg(1, 32'd63);
        rd_reg(24, r); check("R1 enable lo", r, 32'h0010_0408);
        rd_reg(25, r); check("R1 enable hi", r, 32'h8000_0100);

        // R3 / R4 configuration
        wr_reg(9, 32'h100);
        wr_reg(32, 32'h0000_5000);
        wr_reg(33, 32'h0000_0900);
        wr_reg(34, 32'h0009_0000);
        wr_reg(39, 32'h2000_0000);
        rd_reg(39, r); check("R4 prio word7", r, 32'h2000_0000);

        // vector table: R3 R4 R5 R7 R8 R9
        for (int i = 0; i < 12; i++) begin
            wr_reg(0, {27'b0, VEC[i].lvl});
            src = VEC[i].s;
            settle();
            check($sformatf("R7 irq vec%0d", i), {31'b0, irq}, {31'b0, VEC[i].eirq});
            check($sformatf("R8 fiq vec%0d", i), {31'b0, fiq}, {31'b0, VEC[i].efiq});
            rd_reg(3, r);
            check($sformatf("R9 status vec%0d", i), r, VEC[i].est);
        end

        // R11 one-clock response
        wr_reg(0, 32'd31);
        src = '0;
        settle();
        src = 64'h400;
        check("R11 before edge", {31'b0, irq}, 32'd0);
        tick();
        check("R11 after edge", {31'b0, irq}, 32'd1);
        src = '0;
        settle();

        // R6 test bits
        wr_reg(17, 32'h8000_0000);
        settle();
        check("R6 forced irq", {31'b0, irq}, 32'd1);
        rd_reg(3, r); check("R6 forced status", r, 32'd63);
        wr_reg(17, 32'h0);
        wr_reg(16, 32'h20);
        settle();
        check("R5 forced disabled", {31'b0, irq}, 32'd0);
        wr_reg(16, 32'h0);

        // R3 route flip
        wr_reg(9, 32'h0);
        src = 64'h100_0000_0000;
        settle();
        check("R3 irq routed", {31'b0, irq}, 32'd1);
        check("R3 fiq off", {31'b0, fiq}, 32'd0);
        rd_reg(3, r); check("R3 status", r, 32'd40);
        src = '0;

        // R2 clear by number, 67 wraps to 3
        wr_reg(2, 32'd67);
        rd_reg(24, r); check("R2 clear wrap", r, 32'h0010_0400);
        wr_reg(2, 32'd10);
        rd_reg(24, r); check("R2 clear 10", r, 32'h0010_0000);
        src = 64'h8;
        settle();
        check("R2 disabled src", {31'b0, irq}, 32'd0);
        src = '0;

        // R10 reset mid-run
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        rd_reg(25, r); check("R10 enable hi after reset", r, 32'h0);
        rd_reg(0, r);  check("R10 level after reset", r, 32'h1F);
        finish_run();
    end
endmodule